// File: doc/BRIEF.md
# Fine-Grain Warp Issue Scheduler

This block decides which of a set of hardware thread contexts, called warps, sends the next instruction to a shared bank of execution lanes. A warp holds 32 threads that all run one instruction. The bank has only 8 lanes, so one warp instruction is spread over 4 back-to-back cycles called lane groups, with 8 threads in each. The scheduler holds 24 warp contexts. It picks a fresh warp only when the lane bank is free or is in the last group of the current instruction. The next instruction can therefore follow with no idle cycle.

There are two selection policies. In fine-grain mode the chosen warp changes on every instruction. The search runs round-robin from the warp after the last one issued, and any warp whose ready flag is low is passed over. In coarse-grain mode the scheduler stays with the warp it last issued for as long as that warp stays ready. It moves on, in the same circular order, only when that warp stalls. Each cycle the block outputs the chosen warp, the lane group and, for every lane, the thread index that lane carries.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset `issueValid` is 0 and `laneGroup` is 0. The last-issued pointer starts at warp NUM_WARPS-1 (23), so the first fine-grain pick is the lowest-numbered ready warp. Whenever `issueValid` is 0, `laneGroup` is 0.
- R2: An issue occupies exactly 4 consecutive cycles with `issueValid` high. In those cycles `laneGroup` takes the values 0, 1, 2, 3 in order, and `issueWarp` stays constant.
- R3: While an issue is active, lane j carries thread index 8·`laneGroup` + j. The index appears on `laneThread[5j+4:5j]`.
- R4: In fine-grain mode (`coarseMode`=0) the next warp is the first ready warp in the circular order that starts one past the last issued warp. Warp 23 wraps to warp 0.
- R5: A warp whose `warpReady` bit is 0 when a selection is made is never issued.
- R6: A selection is made only in a cycle where no issue is active or where `laneGroup` is 3. `warpReady` changes at any other time have no effect. An issue may start in the cycle right after group 3.
- R7: If no warp is ready, or `start` is 0, when a selection would be made, then `issueValid` is 0 in the next cycle. The last-issued pointer keeps its value, so the search later resumes from the same place.
- R8: In coarse-grain mode (`coarseMode`=1) the search starts at the last issued warp itself. That warp is reissued for as long as it is ready. Once it stalls, the next ready warp after it in circular order is chosen.
- R9: If `start` falls during an issue, the issue still completes all 4 groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Allows new warp instructions to be issued |
| coarseMode | input | 1 | 0 = rotate every instruction, 1 = switch only on stall |
| warpReady | input | NUM_WARPS | Per-warp ready flag; 0 means stalled |
| issueValid | output | 1 | An issue is active this cycle |
| issueWarp | output | WID_W | Warp being issued |
| laneGroup | output | GRP_W | Lane group 0..3 of the current instruction |
| laneThread | output | NUM_LANES·TID_W | Thread index per lane, lane j at bits [TID_W·j +: TID_W] |

## Verification
The assertions assume that `warpReady`, `start` and `coarseMode` are stable around the rising edge. They also assume that a ready flag matters only in the cycle where a selection is made. The bench drives every input at the falling edge and changes ready masks freely, including in the middle of a group. This shows that only the flags present at a selection cycle affect the result. The bench keeps its own round-robin model, computed arithmetically from these rules. It sweeps full, sparse, empty and random masks in both modes, and toggles `start` in the middle of an issue.

// File: rtl/wis_pkg.sv
package wis_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic launch;  // begin a new warp instruction this edge
    logic step;    // advance to the next lane group
    logic retire;  // last group done, no successor
  } schedStrobe_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import wis_pkg::*;
#(
  parameter int GROUPS = 4,
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             anyReady,
  output schedStrobe_t     strobes,
  output logic             issueValid,
  output logic [GRP_W-1:0] laneGroup
);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);

  logic             busy;
  logic [GRP_W-1:0] grp;
  logic             lastGrp;
  logic             slotFree;

  assign lastGrp  = busy && (grp == LAST_GRP);
  assign slotFree = !busy || lastGrp;

  always_comb begin
    strobes        = '0;
    strobes.launch = slotFree && start && anyReady;
    strobes.step   = busy && !lastGrp;
    strobes.retire = lastGrp && !strobes.launch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      grp  <= '0;
    end else if (strobes.launch) begin
      busy <= 1'b1;
      grp  <= '0;
    end else if (strobes.step) begin
      grp  <= grp + 1'b1;
    end else if (strobes.retire) begin
      busy <= 1'b0;
      grp  <= '0;
    end
  end

  assign issueValid = busy;
  assign laneGroup  = grp;

  // R2: a group that is not the last is followed by its successor
  a_r2_group_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grp != LAST_GRP) |=> (busy && grp == $past(grp) + 1'b1));
  // R9: losing start mid-issue never cuts the issue short
  a_r9_finish_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grp != LAST_GRP && !start) |=> busy);
  // R1: idle means group zero
  a_r1_idle_group_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> grp == '0);
  // R7: nothing ready at a free slot gives an idle cycle
  a_r7_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (slotFree && !anyReady) |=> !busy);
endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int NUM_LANES = 8,
  parameter int GROUPS    = 4,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int TID_W = $clog2(NUM_LANES * GROUPS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  schedStrobe_t               strobes,
  input  logic                       coarseMode,
  input  logic [NUM_WARPS-1:0]       warpReady,
  input  logic [GRP_W-1:0]           laneGroup,
  output logic                       anyReady,
  output logic [WID_W-1:0]           issueWarp,
  output logic [NUM_LANES*TID_W-1:0] laneThread
);
  localparam logic [WID_W-1:0] PTR_INIT = WID_W'(NUM_WARPS - 1);

  logic [WID_W-1:0] curWarp;
  logic [WID_W-1:0] pickWarp;
  logic [WID_W:0]   base;
  logic [WID_W:0]   idx;
  logic             found;

  // circular search: from the last warp (coarse) or the one after it (fine)
  always_comb begin
    base     = coarseMode ? {1'b0, curWarp} : ({1'b0, curWarp} + 1'b1);
    found    = 1'b0;
    pickWarp = '0;
    idx      = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      idx = base + (WID_W+1)'(i);
      if (idx >= (WID_W+1)'(NUM_WARPS)) idx = idx - (WID_W+1)'(NUM_WARPS);
      if (!found && warpReady[idx[WID_W-1:0]]) begin
        found    = 1'b1;
        pickWarp = idx[WID_W-1:0];
      end
    end
  end

  assign anyReady = found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              curWarp <= PTR_INIT;
    else if (strobes.launch) curWarp <= pickWarp;
  end

  assign issueWarp = curWarp;

  generate
    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
      assign laneThread[j*TID_W +: TID_W] =
        TID_W'(int'(laneGroup) * NUM_LANES + j);
    end
  endgenerate

  // R5: a launch only happens when the chosen warp is ready
  a_r5_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.launch |-> warpReady[pickWarp]);
  // R7: the pointer moves only on a launch
  a_r7_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.launch |=> $stable(curWarp));
  // R6: control never launches with nothing ready
  a_r6_launch_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.launch |-> anyReady);
  // R8: coarse mode keeps a still-ready warp
  a_r8_coarse_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.launch && coarseMode && warpReady[curWarp]) |=> $stable(curWarp));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS    = 24,
  parameter int NUM_LANES    = 8,
  parameter int WARP_THREADS = 32,
  localparam int GROUPS = WARP_THREADS / NUM_LANES,
  localparam int WID_W  = $clog2(NUM_WARPS),
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int TID_W  = $clog2(WARP_THREADS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       coarseMode,
  input  logic [NUM_WARPS-1:0]       warpReady,
  output logic                       issueValid,
  output logic [WID_W-1:0]           issueWarp,
  output logic [GRP_W-1:0]           laneGroup,
  output logic [NUM_LANES*TID_W-1:0] laneThread
);
  schedStrobe_t strobes;
  logic         anyReady;

  sched_ctrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .anyReady(anyReady),
    .strobes(strobes), .issueValid(issueValid), .laneGroup(laneGroup)
  );

  sched_dp #(.NUM_WARPS(NUM_WARPS), .NUM_LANES(NUM_LANES), .GROUPS(GROUPS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .coarseMode(coarseMode),
    .warpReady(warpReady), .laneGroup(laneGroup), .anyReady(anyReady),
    .issueWarp(issueWarp), .laneThread(laneThread)
  );
endmodule

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 24;
  localparam int NL = 8;
  localparam int NG = 4;
  localparam int TW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          coarseMode = 1'b0;
  logic [NW-1:0] warpReady = '0;
  logic          issueValid;
  logic [4:0]    issueWarp;
  logic [1:0]    laneGroup;
  logic [NL*TW-1:0] laneThread;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int  mPtr = NW - 1;
  bit  mBusy = 0;
  int  mGrp = 0;
  logic [31:0] rng = 32'h1234_5678;

  warp_issue_sched dut (
    .clk(clk), .rst_n(rst_n), .start(start), .coarseMode(coarseMode),
    .warpReady(warpReady), .issueValid(issueValid), .issueWarp(issueWarp),
    .laneGroup(laneGroup), .laneThread(laneThread)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(input string tag);
    check("R2", {tag, " issueValid"}, int'(issueValid), int'(mBusy));
    if (mBusy) begin
      check("R4/R5", {tag, " issueWarp"}, int'(issueWarp), mPtr);
      check("R2", {tag, " laneGroup"}, int'(laneGroup), mGrp);
      for (int j = 0; j < NL; j++)
        check("R3", {tag, " laneThread"}, int'(laneThread[j*TW +: TW]), mGrp*NL + j);
    end else begin
      check("R1", {tag, " idle laneGroup"}, int'(laneGroup), 0);
    end
  endtask

  // one cycle: check at negedge, drive inputs, advance model to next posedge
  task automatic cycle(input string tag, input logic [NW-1:0] rdy, input logic st, input logic cm);
    bit free, found;
    int pick, off0;
    @(negedge clk);
    checkOutputs(tag);
    warpReady  = rdy;
    start      = st;
    coarseMode = cm;
    free  = !mBusy || (mGrp == NG-1);
    found = 0;
    pick  = 0;
    off0  = cm ? 0 : 1;
    for (int o = 0; o < NW; o++) begin
      int w;
      w = (mPtr + off0 + o) % NW;
      if (!found && rdy[w]) begin found = 1; pick = w; end
    end
    if (free && st && found) begin
      mBusy = 1; mGrp = 0; mPtr = pick;
    end else if (mBusy && mGrp < NG-1) begin
      mGrp++;
    end else begin
      mBusy = 0; mGrp = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then first pick is lowest ready warp (3)
    cycle("R1", 24'h000008, 1'b1, 1'b0);
    check("R1", "pointer start", mPtr, 3);
    // R4: all ready, rotation through every warp and wrap
    for (int i = 0; i < 120; i++) cycle("R4", '1, 1'b1, 1'b0);
    // R5: sparse fixed mask with wrap 23 -> 0
    for (int i = 0; i < 60; i++) cycle("R5", 24'h800421, 1'b1, 1'b0);
    // R6: ready mask changes every cycle
    for (int i = 0; i < 200; i++) begin
      rng = nextRand(rng);
      cycle("R6", rng[NW-1:0], 1'b1, 1'b0);
    end
    // R7: nothing ready, then one warp
    for (int i = 0; i < 20; i++) cycle("R7", '0, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cycle("R7", 24'h000080, 1'b1, 1'b0);
    // R9: start drops in mid-issue
    cycle("R9", '1, 1'b1, 1'b0);
    cycle("R9", '1, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) cycle("R9", '1, 1'b0, 1'b0);
    // R8: coarse mode keeps the warp, then switches on stall
    for (int i = 0; i < 24; i++) cycle("R8", '1, 1'b1, 1'b1);
    for (int i = 0; i < 24; i++) cycle("R8", ~(24'(1) << mPtr), 1'b1, 1'b1);
    // R3: long random mix of modes, masks and start
    for (int i = 0; i < 2000; i++) begin
      rng = nextRand(rng);
      cycle("R3", rng[NW-1:0] & {rng[7:0], rng[31:16]}, rng[30] | rng[29], rng[28]);
    end
    cycle("R3", '0, 1'b0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule